// File: doc/BRIEF.md
# Interrupt Aggregator with NMI Select

This block gathers the request lines of up to 32 peripherals, brings them into the processor clock domain through a two-flop synchronizer, and presents them as a vector of processor interrupt inputs. One line, picked by a select field, is also routed to a non-maskable interrupt output. Each line has a read-only identity word that holds a small tag naming which sub-source inside the peripheral raised the request.

A word-addressed register port exposes the identity words, a control word (NMI select plus a test-mode guard bit) and a status word that shows the vector seen by the processor. While the guard bit is clear, the vector tracks the peripherals and status writes do nothing. While it is set, the vector is frozen and software drives it directly: each 1 written to the status word flips the matching line, so a 1 raises an idle line and clears a pending one.

Top module: `irq_aggregator`

## Requirements
- R1: While rst_ni is low, irq_o, nmi_o and every register read are 0, whatever irq_i and src_tag_i carry.
- R2: With test mode off, irq_o[n] equals irq_i[n] as sampled two rising edges earlier; after one edge it still shows the old value.
- R3: The identity word of line n sits at byte offset 4*n. Bits 3:0 hold src_tag_i[4n+3:4n] as captured on the previous edge, and the upper bits read 0. Writes to these words are ignored.
- R4: The control word at offset 0x80 holds the NMI select in bits 4:0 and the test-mode guard in bit 7. All other bits read 0 and cannot be written.
- R5: nmi_o equals irq_o[sel], where sel is the select field. A select write takes effect right after the edge that stores it.
- R6: The status word at offset 0x84 reads back irq_o in bits 31:0.
- R7: With test mode off, writes to the status word have no effect on irq_o.
- R8: Setting the guard bit freezes irq_o at the synchronized value it had at the storing edge. Later changes on irq_i leave irq_o unchanged.
- R9: In test mode, a status write flips every line whose data bit is 1. A line at 0 becomes 1 and a line at 1 becomes 0. Data bits at 0 leave their lines unchanged.
- R10: Clearing the guard bit makes irq_o follow the synchronizer output again from the next cycle.
- R11: Reads of word offsets above 0x84 return 0, and address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 32 | Peripheral request lines, asynchronous |
| src_tag_i | input | 128 | Sub-source tag per line, 4 bits each, line n in bits 4n+3:4n |
| reg_addr_i | input | 8 | Byte address of the register access |
| reg_we_i | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from reg_addr_i |
| irq_o | output | 32 | Interrupt vector to the processor |
| nmi_o | output | 1 | Non-maskable interrupt |

## Verification
A stuck or miswired synchronizer stage shows on irq_o two edges after an input change, as a wrong bit or a wrong delay. A broken injection register shows on the first status write in test mode, as a vector that does not equal the previous vector XOR the data. A wrong select decode shows on nmi_o immediately after the control write. Every line, every select value and every identity word is swept, so a fault in a single index cannot stay hidden.

// File: rtl/aggr_pkg.sv
package aggr_pkg;
  localparam int unsigned REG_DW   = 32;
  localparam int unsigned TEST_BIT = 7;
endpackage

// File: rtl/aggr_sync.sv
module aggr_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/aggr_src_ids.sv
module aggr_src_ids #(
  parameter int unsigned NUM_IRQ = 32,
  parameter int unsigned SRC_W   = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_IRQ*SRC_W-1:0] tag_i,
  output logic [SRC_W-1:0]         id_o [NUM_IRQ]
);
  for (genvar n = 0; n < NUM_IRQ; n++) begin : g_id
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) id_o[n] <= '0;
      else         id_o[n] <= tag_i[n*SRC_W +: SRC_W];
    end
  end
endmodule

// File: rtl/aggr_ctrl.sv
module aggr_ctrl #(
  parameter int unsigned NUM_IRQ = 32,
  localparam int unsigned SEL_W  = $clog2(NUM_IRQ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctrl_we_i,
  input  logic               stat_we_i,
  input  logic [31:0]        wdata_i,
  input  logic [NUM_IRQ-1:0] sync_i,
  output logic [SEL_W-1:0]   sel_o,
  output logic               test_o,
  output logic [NUM_IRQ-1:0] inj_o
);
  import aggr_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o  <= '0;
      test_o <= 1'b0;
    end else if (ctrl_we_i) begin
      sel_o  <= wdata_i[SEL_W-1:0];
      test_o <= wdata_i[TEST_BIT];
    end
  end

  // injection register shadows the synchronizer until test mode freezes it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        inj_o <= '0;
    else if (!test_o)   inj_o <= sync_i;
    else if (stat_we_i) inj_o <= inj_o ^ wdata_i[NUM_IRQ-1:0];
  end

  assert_inj_toggle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_o && stat_we_i) |=> (inj_o == ($past(inj_o) ^ $past(wdata_i[NUM_IRQ-1:0]))));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int unsigned NUM_IRQ = 32,
  parameter int unsigned SRC_W   = 4,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_IRQ-1:0]       irq_i,
  input  logic [NUM_IRQ*SRC_W-1:0] src_tag_i,
  input  logic [ADDR_W-1:0]        reg_addr_i,
  input  logic                     reg_we_i,
  input  logic [31:0]              reg_wdata_i,
  output logic [31:0]              reg_rdata_o,
  output logic [NUM_IRQ-1:0]       irq_o,
  output logic                     nmi_o
);
  import aggr_pkg::*;

  localparam int unsigned SEL_W = $clog2(NUM_IRQ);
  localparam int unsigned IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] CTRL_IDX = IDX_W'(NUM_IRQ);
  localparam logic [IDX_W-1:0] STAT_IDX = IDX_W'(NUM_IRQ + 1);

  logic [NUM_IRQ-1:0] sync_q, inj_q;
  logic [SRC_W-1:0]   id_q [NUM_IRQ];
  logic [SEL_W-1:0]   sel_q;
  logic               test_q;
  logic [IDX_W-1:0]   idx;
  logic               ctrl_we, stat_we;

  assign idx     = reg_addr_i[ADDR_W-1:2];
  assign ctrl_we = reg_we_i && (idx == CTRL_IDX);
  assign stat_we = reg_we_i && (idx == STAT_IDX);

  aggr_sync #(.WIDTH(NUM_IRQ), .STAGES(2)) u_sync (
    .clk_i, .rst_ni, .d_i(irq_i), .q_o(sync_q));

  aggr_src_ids #(.NUM_IRQ(NUM_IRQ), .SRC_W(SRC_W)) u_ids (
    .clk_i, .rst_ni, .tag_i(src_tag_i), .id_o(id_q));

  aggr_ctrl #(.NUM_IRQ(NUM_IRQ)) u_ctrl (
    .clk_i, .rst_ni, .ctrl_we_i(ctrl_we), .stat_we_i(stat_we),
    .wdata_i(reg_wdata_i), .sync_i(sync_q),
    .sel_o(sel_q), .test_o(test_q), .inj_o(inj_q));

  assign irq_o = test_q ? inj_q : sync_q;
  assign nmi_o = irq_o[sel_q];

  always_comb begin
    reg_rdata_o = '0;
    if (idx < CTRL_IDX) begin
      reg_rdata_o[SRC_W-1:0] = id_q[idx[SEL_W-1:0]];
    end else if (idx == CTRL_IDX) begin
      reg_rdata_o[SEL_W-1:0] = sel_q;
      reg_rdata_o[TEST_BIT]  = test_q;
    end else if (idx == STAT_IDX) begin
      reg_rdata_o[NUM_IRQ-1:0] = irq_o;
    end
  end

  // assertions
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           warm_q <= '0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  assert_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!test_q && warm_q == 2'd2) |-> (irq_o == $past(irq_i, 2)));
  assert_nmi_sel_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we |=> (nmi_o == irq_o[$past(reg_wdata_i[SEL_W-1:0])]));
  assert_freeze_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_q && !stat_we && !ctrl_we) |=> $stable(irq_o));
  assert_toggle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_q && stat_we) |=> (irq_o == ($past(irq_o) ^ $past(reg_wdata_i[NUM_IRQ-1:0]))));
  assert_unmapped_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx > STAT_IDX) |-> (reg_rdata_o == '0));
endmodule

// File: tb/irq_aggregator_tb.sv
`timescale 1ns/1ps
module irq_aggregator_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [31:0]  irq = '0;
  logic [127:0] tags = '0;
  logic [7:0]   addr = 8'hFC;
  logic         we = 1'b0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata, irq_out;
  logic         nmi;
  int           vectors = 0;
  int           fails = 0;

  always #2.5 clk = ~clk;

  irq_aggregator u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .src_tag_i(tags),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq_out), .nmi_o(nmi));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; addr = 8'hFC;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  function automatic logic [3:0] tag_of(input int n, input int salt);
    return 4'((n * 7 + salt) & 15);
  endfunction

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] r, pat, exp;
    // R1: reset holds everything at zero
    irq = '1;
    for (int n = 0; n < 32; n++) tags[n*4 +: 4] = 4'hF;
    repeat (4) @(negedge clk);
    chk("R1 irq_o", irq_out, 32'h0);
    chk("R1 nmi_o", {31'h0, nmi}, 32'h0);
    for (int n = 0; n < 34; n++) begin
      rd(8'(n * 4), r);
      chk("R1 reg", r, 32'h0);
    end
    irq = '0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2/R6: walk each line, check one-edge and two-edge delays
    for (int n = 0; n < 32; n++) begin
      pat = (32'h1 << n) ^ 32'h0F00_00F0;
      exp = irq;
      irq = pat;
      @(negedge clk);
      chk("R2 one edge", irq_out, exp);
      @(negedge clk);
      chk("R2 two edges", irq_out, pat);
      rd(8'h84, r);
      chk("R6 status", r, pat);
    end

    // R3/R11: identity words, address low bits ignored, writes ignored
    for (int n = 0; n < 32; n++) tags[n*4 +: 4] = tag_of(n, 3);
    @(negedge clk);
    for (int n = 0; n < 32; n++) begin
      rd(8'(n * 4 + (n % 4)), r);
      chk("R3 id read", r, {28'h0, tag_of(n, 3)});
    end
    for (int n = 0; n < 32; n += 5) begin
      wr(8'(n * 4), 32'hFFFF_FFFF);
      rd(8'(n * 4), r);
      chk("R3 id write ignored", r, {28'h0, tag_of(n, 3)});
    end

    // R4/R5: sweep every select value
    pat = 32'hA5C3_961E;
    irq = pat;
    repeat (3) @(negedge clk);
    for (int s = 0; s < 32; s++) begin
      wr(8'h80, 32'hFFFF_FF60 | 32'(s));
      rd(8'h80, r);
      chk("R4 ctrl read", r, 32'(s));
      chk("R5 nmi", {31'h0, nmi}, {31'h0, pat[s]});
    end

    // R7: status write in normal mode
    wr(8'h84, 32'hFFFF_FFFF);
    chk("R7 write ignored", irq_out, pat);

    // R8: enter test mode, vector frozen
    wr(8'h80, 32'h0000_0083);
    rd(8'h80, r);
    chk("R4 test bit", r, 32'h0000_0083);
    chk("R8 frozen at entry", irq_out, pat);
    irq = ~pat;
    repeat (4) @(negedge clk);
    chk("R8 inputs ignored", irq_out, pat);
    chk("R5 nmi in test", {31'h0, nmi}, {31'h0, pat[3]});

    // R9: toggle injection
    exp = pat;
    for (int k = 0; k < 8; k++) begin
      r = 32'h1357_9BDF * 32'(k + 1) ^ (32'h1 << (k * 4));
      exp ^= r;
      wr(8'h84, r);
      chk("R9 toggle", irq_out, exp);
      rd(8'h84, r);
      chk("R9 status", r, exp);
    end
    wr(8'h84, 32'h0);
    chk("R9 zero write", irq_out, exp);
    wr(8'h84, exp);
    chk("R9 clear all", irq_out, 32'h0);

    // R10: leave test mode
    wr(8'h80, 32'h0);
    chk("R10 resume", irq_out, ~pat);

    // R11: unmapped words
    for (int a = 8'h88; a <= 8'hFC; a += 4) begin
      rd(8'(a), r);
      chk("R11 unmapped", r, 32'h0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule